// File: doc/BRIEF.md
# Dual-Bank FIR Multiply-Accumulate Engine

This block computes a direct-form FIR filter. It finishes one tap in every clock cycle. Filter taps live in a coefficient register bank. The most recent input samples live in a second bank, organised as a circular delay line. Each bank has its own read port, so each cycle can fetch one coefficient and one sample together. A single-cycle signed multiplier feeds an accumulator. The accumulator is wide enough that a full sum over every tap can never wrap.

Samples enter through a valid/ready stream. The engine raises `in_ready` only while idle. A transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. From the next cycle onward, `in_ready` stays low until the result appears, and that is the whole back-pressure rule.

The result leaves on `out_data` together with a one-cycle `out_valid` strobe. The output has no ready input, so the consumer must take it in that cycle. Coefficients are written through a plain write port. A write lands only while the engine is idle.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. Every coefficient and every stored sample is zero.
- R2: For the n-th accepted sample, the result equals the sum over k = 0..TAPS-1 of coef[k] * x[n-k]. Samples and coefficients are 16-bit two's complement. Samples that come before the first one accepted since reset count as zero.
- R3: `out_valid` is high for exactly one cycle, TAPS rising edges after the edge that accepted the sample. This is one multiply-accumulate per cycle with no stall.
- R4: `in_ready` is low from the cycle after acceptance through the cycle before `out_valid`. An `in_valid` pulse during that window leaves the delay line unchanged.
- R5: A coefficient write (`coef_we` = 1) issued while `in_ready` is 0 is ignored.
- R6: A coefficient write issued while idle sets coef[`coef_addr`] and is used by every later computation.
- R7: The delay line wraps. After more than TAPS samples, only the newest TAPS samples contribute.
- R8: The accumulator starts from zero for each output. No part of an earlier sum carries into a later result.
- R9: The result is a signed value of 32 + log2(TAPS) bits that cannot overflow. With every coefficient and sample at -32768, the result is TAPS * 2^30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine idle; sample can be taken |
| in_data | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | log2(TAPS) | Coefficient index (tap k) |
| coef_data | input | 16 | Signed coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 32+log2(TAPS) | Signed filter result |

## Verification
The hardest cases to reach are stimulus that arrives while a sum is in progress. These are stray sample offers and coefficient writes, and they must leave no mark. The bench places a junk `in_valid` pulse and a junk coefficient write in the first busy cycle of many computations. Any leak then appears as a wrong result on later outputs. Full-scale negative operands push the accumulator to its largest magnitude. Long runs of random samples force the delay line to wrap many times.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} eng_state_t;

  // Index of the sample k steps older than position head in a ring of n entries.
  function automatic int unsigned ring_back(int unsigned head, int unsigned k, int unsigned n);
    if (head >= k) return head - k;
    else return head + n - k;
  endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int TAPS   = 16,
  parameter int COEF_W = 16,
  localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic signed [COEF_W-1:0] wdata,
  input  logic [AW-1:0]            raddr,
  output logic signed [COEF_W-1:0] rdata
);
  logic signed [COEF_W-1:0] store [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store[i] <= '0;
      else if (we && (int'(waddr) == i)) store[i] <= wdata;
    end

    a_r6_coef_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(waddr) == i) |=> (store[i] == $past(wdata)));
    a_r5_coef_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(store[i]));
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fir_sample_line.sv
module fir_sample_line #(
  parameter int TAPS   = 16,
  parameter int DATA_W = 16,
  localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic signed [DATA_W-1:0] push_data,
  input  logic [AW-1:0]            age,
  output logic signed [DATA_W-1:0] tap_data
);
  import fir_pkg::*;

  logic signed [DATA_W-1:0] line [TAPS];
  logic [AW-1:0] head;
  logic [AW-1:0] slot_nxt;
  logic [AW-1:0] rd_idx;

  assign slot_nxt = (int'(head) == TAPS-1) ? '0 : head + 1'b1;
  assign rd_idx   = AW'(ring_back(int'(head), int'(age), TAPS));
  assign tap_data = line[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head <= AW'(TAPS-1);
    else if (push) head <= slot_nxt;
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line[i] <= '0;
      else if (push && (int'(slot_nxt) == i)) line[i] <= push_data;
    end
  end

  a_r4_head_still: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(head));
  a_r7_newest_stored: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (line[head] == $past(push_data)));
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     first,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc_next
);
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  base;

  assign prod     = sample * coef;
  assign prod_ext = ACC_W'(prod);
  assign base     = first ? '0 : acc_q;
  assign acc_next = base + prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (en) acc_q <= acc_next;
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (base[ACC_W-1] == prod_ext[ACC_W-1])) |-> (acc_next[ACC_W-1] == base[ACC_W-1]));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
  parameter int TAPS   = 16,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int AW    = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ACC_W = DATA_W + COEF_W + AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     coef_we,
  input  logic [AW-1:0]            coef_addr,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  out_data
);
  import fir_pkg::*;

  eng_state_t state;
  logic [AW-1:0] tap_k;
  logic accept, busy, last_tap;
  logic signed [COEF_W-1:0] cur_coef;
  logic signed [DATA_W-1:0] cur_smp;
  logic signed [ACC_W-1:0]  acc_next;

  assign busy     = (state == ST_BUSY);
  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign last_tap = (int'(tap_k) == TAPS-1);

  fir_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) u_coef (
    .clk(clk), .rst_n(rst_n),
    .we(coef_we && in_ready), .waddr(coef_addr), .wdata(coef_data),
    .raddr(tap_k), .rdata(cur_coef)
  );

  fir_sample_line #(.TAPS(TAPS), .DATA_W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_data(in_data),
    .age(tap_k), .tap_data(cur_smp)
  );

  fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .en(busy), .first(tap_k == '0),
    .sample(cur_smp), .coef(cur_coef), .acc_next(acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tap_k     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_BUSY;
          tap_k <= '0;
        end
        ST_BUSY: if (last_tap) begin
          state     <= ST_IDLE;
          tap_k     <= '0;
          out_valid <= 1'b1;
          out_data  <= acc_next;
        end else begin
          tap_k <= tap_k + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Latency checker: edges counted since the accepting edge.
  logic [AW+1:0] since_acc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_acc <= '1;
    else if (accept) since_acc <= '0;
    else if (since_acc != '1) since_acc <= since_acc + 1'b1;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(since_acc) == TAPS));
  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r4_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

// File: tb/fir_mac_engine_test.sv
module fir_mac_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 16;
  localparam int AW = $clog2(TAPS);
  localparam int ACC_W = 32 + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_data = '0;
  logic coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic signed [15:0] coef_data = '0;
  logic out_valid;
  logic signed [ACC_W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  longint cm [TAPS];
  longint hist [TAPS];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_mac_engine #(.TAPS(TAPS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_out();
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += cm[k] * hist[k];
    return s;
  endfunction

  task automatic load_coef(input int a, input int d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = AW'(a); coef_data = 16'(d);
    @(negedge clk);
    coef_we = 1'b0;
    cm[a] = longint'($signed(16'(d)));
  endtask

  // Sends one sample; optionally pokes junk during the first busy cycle.
  task automatic send(input int x, input bit junk, input string req);
    int cnt;
    longint exp;
    @(negedge clk);
    check(in_ready == 1'b1, "R4", longint'(in_ready), 1);
    in_valid = 1'b1; in_data = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(16'(x)));
    check(in_ready == 1'b0, "R4", longint'(in_ready), 0);
    if (junk) begin
      in_valid = 1'b1; in_data = 16'h7abc;
      coef_we = 1'b1; coef_addr = AW'($urandom_range(TAPS-1)); coef_data = 16'h5a5a;
    end
    cnt = 0;
    while (cnt < TAPS + 4) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      in_valid = 1'b0; coef_we = 1'b0;
      if (out_valid) break;
    end
    check(cnt == TAPS, "R3", cnt, TAPS);
    exp = model_out();
    check(longint'(out_data) == exp, req, longint'(out_data), exp);
    @(negedge clk);
    check(out_valid == 1'b0, "R3", longint'(out_valid), 0);
  endtask

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240607);
    for (int k = 0; k < TAPS; k++) begin cm[k] = 0; hist[k] = 0; end
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", longint'(in_ready), 1);

    // R1: zeroed coefficients give zero output
    send(1234, 1'b0, "R1");

    // R6/R2: impulse response walks through the taps
    for (int k = 0; k < TAPS; k++) load_coef(k, k * 3 - 20);
    send(1, 1'b0, "R2");
    for (int k = 1; k < TAPS + 3; k++) send(0, 1'b0, "R7");

    // R5/R4: junk during busy cycles must not leak
    for (int i = 0; i < 8; i++) send($urandom_range(65535), 1'b1, "R5");

    // R9: full-scale negative operands
    for (int k = 0; k < TAPS; k++) load_coef(k, -32768);
    for (int i = 0; i < TAPS; i++) send(-32768, 1'b0, "R9");
    check(longint'(out_data) == (longint'(TAPS) << 30), "R9",
          longint'(out_data), longint'(TAPS) << 30);

    // R2/R7/R8: random traffic with occasional idle coefficient updates
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(3) == 0) load_coef($urandom_range(TAPS-1), $urandom_range(65535));
      send($urandom_range(65535), ($urandom_range(1) == 1), "R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule